// File: doc/BRIEF.md
# One-Address Accumulator Core with Slow Memory

This block is a small accumulator processor that executes a one-address program from a single shared memory port. Instruction words and data words both pass over that port. Each memory access is slow compared with an internal step, so the core waits for a ready handshake on every request. Every instruction takes two bus words: an opcode word, then an operand word. For memory instructions the operand word is a 32-bit word address. For the divide instruction it is an unsigned 32-bit divisor.

The core supports four operations: load the accumulator, add a memory word to it, store it to memory, and divide it by an immediate. A halt ends the program. A free-running counter of elapsed clock cycles stops when the core halts. Its final value is the cost of the program, and that cost is dominated by memory waits. A system places the program at word address zero, releases reset, and reads the accumulator and the cycle total once `halted` rises.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `acc` and `cycle_count` are 0 and `halted` and `div_err` are 0. The first request is a read (`mem_we`=0) of word address 0.
- R2: Each instruction is two words read in order from PC and PC+1. The operation code is bits 7:0 of the first word and the operand is the whole second word. The PC then advances by 2.
- R3: When `mem_req` is high and `mem_ready` is low at a clock edge, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` keep their values into the next cycle.
- R4: Code 0x01 (load) reads the word at the operand address and puts it in `acc`.
- R5: Code 0x03 (add) reads the word at the operand address and adds it to `acc`, modulo 2^32.
- R6: Code 0x02 (store) issues one write (`mem_we`=1) of `acc` to the operand address. `acc` does not change.
- R7: Code 0x04 (divide) sets `acc` to the unsigned quotient of `acc` by the operand word and makes no data memory access.
- R8: A divide by zero leaves `acc` unchanged and sets `div_err`. `div_err` stays set until reset, including through later divides.
- R9: Code 0xFF halts the core, and so does every code not listed in R4 to R7. After a halt, `halted` stays high, `mem_req` stays low, and no later instruction executes.
- R10: `cycle_count` increments by one in every clock cycle from reset release until the halt decode, and is frozen afterwards. A memory access costs every cycle from its request to the cycle in which ready is seen. Decoding costs 1 cycle. Load, add and divide each cost 1 more execute cycle.
- R11: Bits 31:8 of the opcode word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Access complete |
| halted | output | 1 | Core stopped |
| div_err | output | 1 | Sticky divide-by-zero flag |
| acc | output | 32 | Accumulator |
| cycle_count | output | 32 | Elapsed cycles until halt |

## Verification
A wrong state step or a PC error shows up at the ports within one access. The next request carries an unexpected address or direction, or the final `cycle_count` differs from the total predicted from the instruction mix. A divide that reaches memory by mistake adds a whole access to the total. An arithmetic error appears in `acc` or in the stored word once the program halts. A halt that fails to stick shows as renewed requests or a counter that keeps moving within a few cycles.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int OPC_W = 8;

    typedef enum logic [OPC_W-1:0] {
        OPC_LOAD  = 8'h01,
        OPC_STORE = 8'h02,
        OPC_ADD   = 8'h03,
        OPC_DIV   = 8'h04,
        OPC_HALT  = 8'hFF
    } opc_e;

    typedef enum logic [2:0] {
        ST_FETCH_OP,
        ST_FETCH_ARG,
        ST_DECODE,
        ST_DATA_RD,
        ST_DATA_WR,
        ST_EXEC,
        ST_STOP
    } core_st_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OPC_W-1:0] op,
    input  logic [W-1:0]     acc_in,
    input  logic [W-1:0]     operand,
    output logic [W-1:0]     result,
    output logic             div_zero
);
    always_comb begin
        result   = acc_in;
        div_zero = 1'b0;
        case (op)
            OPC_LOAD: result = operand;
            OPC_ADD:  result = acc_in + operand;
            OPC_DIV: begin
                if (operand == '0) begin
                    div_zero = 1'b1;
                end else begin
                    result = acc_in / operand;
                end
            end
            default: result = acc_in;
        endcase
    end
endmodule

// File: rtl/acc_cycle_ctr.sv
module acc_cycle_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        run |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt_q));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_pkg::*;
#(
    parameter int          W        = 32,
    parameter int          CNT_W    = 32,
    parameter logic [31:0] START_PC = 32'h0
) (
    input  logic             clk,
    input  logic             rst,
    output logic             mem_req,
    output logic             mem_we,
    output logic [W-1:0]     mem_addr,
    output logic [W-1:0]     mem_wdata,
    input  logic [W-1:0]     mem_rdata,
    input  logic             mem_ready,
    output logic             halted,
    output logic             div_err,
    output logic [W-1:0]     acc,
    output logic [CNT_W-1:0] cycle_count
);
    localparam logic [W-1:0] PC_STEP = W'(2);

    typedef struct packed {
        core_st_e         st;
        logic [W-1:0]     pc;
        logic [OPC_W-1:0] op;
        logic [W-1:0]     arg;
        logic [W-1:0]     opnd;
        logic [W-1:0]     acc;
        logic             err;
    } core_t;

    core_t r_d, r_q;

    logic [W-1:0] alu_res;
    logic         alu_dz;
    logic [W-1:0] alu_operand;

    assign alu_operand = (r_q.op == OPC_DIV) ? r_q.arg : r_q.opnd;

    acc_alu #(.W(W)) alu_i (
        .op       (r_q.op),
        .acc_in   (r_q.acc),
        .operand  (alu_operand),
        .result   (alu_res),
        .div_zero (alu_dz)
    );

    acc_cycle_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk   (clk),
        .rst   (rst),
        .run   (r_q.st != ST_STOP),
        .count (cycle_count)
    );

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.pc;
        mem_wdata = r_q.acc;
        case (r_q.st)
            ST_FETCH_OP: begin
                mem_req  = 1'b1;
                mem_addr = r_q.pc;
                if (mem_ready) begin
                    r_d.op = mem_rdata[OPC_W-1:0];
                    r_d.st = ST_FETCH_ARG;
                end
            end
            ST_FETCH_ARG: begin
                mem_req  = 1'b1;
                mem_addr = r_q.pc + W'(1);
                if (mem_ready) begin
                    r_d.arg = mem_rdata;
                    r_d.pc  = r_q.pc + PC_STEP;
                    r_d.st  = ST_DECODE;
                end
            end
            ST_DECODE: begin
                case (r_q.op)
                    OPC_LOAD, OPC_ADD: r_d.st = ST_DATA_RD;
                    OPC_STORE:         r_d.st = ST_DATA_WR;
                    OPC_DIV:           r_d.st = ST_EXEC;
                    default:           r_d.st = ST_STOP;
                endcase
            end
            ST_DATA_RD: begin
                mem_req  = 1'b1;
                mem_addr = r_q.arg;
                if (mem_ready) begin
                    r_d.opnd = mem_rdata;
                    r_d.st   = ST_EXEC;
                end
            end
            ST_DATA_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.arg;
                mem_wdata = r_q.acc;
                if (mem_ready) r_d.st = ST_FETCH_OP;
            end
            ST_EXEC: begin
                r_d.acc = alu_res;
                r_d.err = r_q.err | alu_dz;
                r_d.st  = ST_FETCH_OP;
            end
            default: r_d.st = ST_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st   <= ST_FETCH_OP;
            r_q.pc   <= START_PC;
            r_q.op   <= '0;
            r_q.arg  <= '0;
            r_q.opnd <= '0;
            r_q.acc  <= '0;
            r_q.err  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign halted  = (r_q.st == ST_STOP);
    assign div_err = r_q.err;
    assign acc     = r_q.acc;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_we) && $stable(mem_wdata)));

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !mem_req));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        div_err |=> div_err);

    // R7
    div_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_DECODE && r_q.op == OPC_DIV) |=> !mem_req);

    // R6
    store_acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> $stable(acc));
endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb_top;
    localparam int CLK_P = 10;
    localparam int LAT   = 10;
    localparam int ACC_C = LAT + 1;
    localparam int C_LA  = 3*ACC_C + 2;
    localparam int C_ST  = 3*ACC_C + 1;
    localparam int C_DV  = 2*ACC_C + 2;
    localparam int C_HL  = 2*ACC_C + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req, mem_we, mem_ready, halted, div_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, acc, cycle_count;

    logic [31:0] mem [0:63];
    int          lat_cnt;
    int          checks = 0;
    int          errors = 0;
    int          r3_viol = 0;
    logic        pend;
    logic [31:0] pend_addr;

    always #(CLK_P/2) clk = ~clk;

    acc_cpu dut_i (
        .clk(clk), .rst(rst),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .halted(halted), .div_err(div_err), .acc(acc), .cycle_count(cycle_count)
    );

    always @(posedge clk) begin
        if (rst) begin
            lat_cnt   <= 0;
            mem_ready <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ready <= 1'b0;
            if (mem_req && !mem_ready) begin
                if (lat_cnt == LAT-1) begin
                    lat_cnt   <= 0;
                    mem_ready <= 1'b1;
                    if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
                    else        mem_rdata <= mem[mem_addr[5:0]];
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else begin
            if (pend && (mem_req !== 1'b1 || mem_addr !== pend_addr)) r3_viol = r3_viol + 1;
            pend      <= mem_req && !mem_ready;
            pend_addr <= mem_addr;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        mem[40] = 32'd7;
        mem[41] = 32'hFFFF_FFFE;
        mem[42] = 32'd100;
        mem[44] = 32'hDEAD_BEEF;
    endtask

    task automatic put(input int slot, input logic [31:0] op, input logic [31:0] arg);
        mem[2*slot]   = op;
        mem[2*slot+1] = arg;
    endtask

    task automatic start();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_to_halt();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (halted) break;
        end
    endtask

    task automatic t_reset();
        clear_mem();
        put(0, 32'h0000_00FF, 32'h0);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 acc in reset", acc, 32'h0);
        chk("R1 count in reset", cycle_count, 32'h0);
        chk("R1 halted in reset", {31'h0, halted}, 32'h0);
        chk("R1 div_err in reset", {31'h0, div_err}, 32'h0);
        rst = 1'b0;
        #1;
        chk("R1 first request", {30'h0, mem_req, mem_we}, 32'h2);
        chk("R1 first address", mem_addr, 32'h0);
        @(negedge clk);
        chk("R2 opcode fetch holds PC", mem_addr, 32'h0);
        run_to_halt();
        chk("R10 halt-only program cost", cycle_count, C_HL);
    endtask

    task automatic t_load_add_store();
        clear_mem();
        put(0, 32'h01, 32'd40);
        put(1, 32'h03, 32'd41);
        put(2, 32'h02, 32'd43);
        put(3, 32'hFF, 32'h0);
        start();
        for (int i = 0; i < ACC_C; i++) @(negedge clk);
        chk("R2 operand word at PC+1", mem_addr, 32'h1);
        run_to_halt();
        chk("R5 add wraps", acc, 32'd5);
        chk("R6 stored word", mem[43], 32'd5);
        chk("R4 R5 R6 program cost", cycle_count, 2*C_LA + C_ST + C_HL);
        chk("R9 halted", {31'h0, halted}, 32'h1);
        repeat (30) @(negedge clk);
        chk("R10 count frozen", cycle_count, 2*C_LA + C_ST + C_HL);
        chk("R9 no request after halt", {31'h0, mem_req}, 32'h0);
    endtask

    task automatic t_div();
        clear_mem();
        put(0, 32'h01, 32'd42);
        put(1, 32'hABCD_0004, 32'd7);
        put(2, 32'h02, 32'd45);
        put(3, 32'hFF, 32'h0);
        start();
        run_to_halt();
        chk("R7 quotient", acc, 32'd14);
        chk("R11 upper opcode bits ignored", mem[45], 32'd14);
        chk("R7 divide has no data access", cycle_count, C_LA + C_DV + C_ST + C_HL);
        chk("R8 no error on nonzero", {31'h0, div_err}, 32'h0);
    endtask

    task automatic t_div_zero();
        clear_mem();
        put(0, 32'h01, 32'd42);
        put(1, 32'h04, 32'd0);
        put(2, 32'h04, 32'd5);
        put(3, 32'hFF, 32'h0);
        start();
        for (int i = 0; i < C_LA + C_DV; i++) @(negedge clk);
        chk("R8 zero divide keeps acc", acc, 32'd100);
        chk("R8 error raised", {31'h0, div_err}, 32'h1);
        run_to_halt();
        chk("R8 later divide runs", acc, 32'd20);
        chk("R8 error sticky", {31'h0, div_err}, 32'h1);
    endtask

    task automatic t_undefined();
        clear_mem();
        put(0, 32'h01, 32'd40);
        put(1, 32'h33, 32'd0);
        put(2, 32'h02, 32'd44);
        put(3, 32'hFF, 32'h0);
        start();
        run_to_halt();
        chk("R9 undefined code halts", {31'h0, halted}, 32'h1);
        chk("R10 undefined halt cost", cycle_count, C_LA + C_HL);
        repeat (40) @(negedge clk);
        chk("R9 later store not done", mem[44], 32'hDEAD_BEEF);
        chk("R9 acc held", acc, 32'd7);
        chk("R3 request stable while waiting", r3_viol, 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P*150000);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual=running expected=halt");
        finish_run();
    end

    initial begin
        t_reset();
        t_load_add_store();
        t_div();
        t_div_zero();
        t_undefined();
        finish_run();
    end
endmodule